// File: doc/BRIEF.md
# Tagged Lookup Table with Configuration Upset Emulation

This block models one k-input lookup table whose truth-table bits can be hit by single-bit upsets. Each input and the output is a tagged signal of two bits that carries a logic value and a flag saying whether that value differs from the value a fault-free circuit would carry. Tagged outputs from several copies can be wired into tagged inputs of others, so the way an error spreads through a netlist of such tables can be traced one cycle at a time.

The block keeps a truth table and a set of injected upsets. The set is held as a mask with one bit per truth-table entry. For each input it makes two evaluations. The actual one uses the upset table (truth table XOR mask) and the input values as they arrive. The golden one uses the clean truth table and the fault-free input values, which are recovered from the tags. The output value is the actual result, and the output is flagged faulty exactly when the two results disagree. A separate strobe shows when the current pattern lands on an upset entry and that upset reaches the output.

A host loads the truth table through a write port and sets or clears single upsets through a second port. Each upset is named by the integer value of the input pattern that exposes it. The data path from the tagged inputs to the tagged output is combinational.

Top module: `tagged_lut_emu`

## Requirements
- R1: After reset the truth table and the upset mask are all zero, so every clean input pattern gives output value 0 with faulty flag 0.
- R2: A write with `cfg_we` high stores `cfg_table`. Entry i of the table is bit i. With clean inputs the output value is then bit i of the stored table and the faulty flag is 0.
- R3: An upset at entry i inverts the output value only when the actual input pattern equals i, and the output is flagged faulty then. Every other clean pattern still gives the unchanged table value with flag 0.
- R4: Input pattern index i is formed with input 0 as the least significant bit. An upset label equals the index of the pattern that exposes it, so label 3 of a 2-input table is the pattern with both inputs at 1.
- R5: A tagged signal is two bits, {faulty, value}. Input j sits at `din[2j+1:2j]`, and its fault-free value is value XOR faulty. The output uses the same encoding on `dout`.
- R6: The output faulty flag is 1 exactly when the upset table at the actual pattern differs from the clean table at the fault-free pattern. A faulty input can therefore be masked to a clean output: in an OR of inputs 0 and 1, a clean 1 on input 0 with a faulty 1 on input 1 gives a clean 1.
- R7: Several upsets can be held at once. `flt_valid` with `flt_inject`=1 sets the entry named by `flt_label`, and with `flt_inject`=0 clears only that entry. All other entries keep their state.
- R8: `activated` is 1 exactly when the actual input pattern hits a set mask entry and the output is flagged faulty.
- R9: Loading a new truth table does not change the upset mask, and cycles without `flt_valid` leave the mask unchanged.
- R10: Table and mask writes take effect at the clock edge that samples them. The output follows `din` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Truth-table write strobe |
| cfg_table | input | 2**K | Truth table to store, bit i for input pattern i |
| flt_valid | input | 1 | Upset command strobe |
| flt_inject | input | 1 | 1 sets the labelled upset, 0 clears it |
| flt_label | input | K | Upset label, equal to the index of the exposing input pattern |
| din | input | 2*K | Tagged inputs, {faulty, value} per input |
| dout | output | 2 | Tagged output, {faulty, value} |
| activated | output | 1 | The current pattern hits an upset that reaches the output |

## Verification
Every clean input pattern is swept after reset, after a table load, and after single and combined upsets. These sweeps show that an upset stays local to its own pattern and that the label order is correct. With one upset present, all 64 tagged input combinations of a 3-input table are compared against an arithmetic model. This separates recovery of the fault-free inputs from plain use of the raw values, and shows masked faulty inputs apart from propagated ones. Targeted cases cover OR masking, a table reload that keeps the mask, clearing one of two upsets, and the edge at which each write becomes visible.

// File: rtl/lutemu_pkg.sv
package lutemu_pkg;
  // Tagged signal layout: {faulty, value}
  localparam int unsigned TAG_W      = 2;
  localparam int unsigned VALUE_POS  = 0;
  localparam int unsigned FAULTY_POS = 1;

  typedef enum logic {
    FLT_CLEAR  = 1'b0,
    FLT_INJECT = 1'b1
  } flt_op_e;
endpackage

// File: rtl/lutemu_rst_sync.sv
module lutemu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lutemu_table_reg.sv
module lutemu_table_reg #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] table_q
);
  logic [N-1:0] table_d;

  always_comb begin
    table_d = table_q;
    if (we) begin
      table_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      table_q <= '0;
    end else if (we) begin
      table_q <= table_d;
    end
  end
endmodule

// File: rtl/lutemu_fault_mask.sv
module lutemu_fault_mask
  import lutemu_pkg::*;
#(
  parameter int unsigned K = 6,
  localparam int unsigned N = 1 << K
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  flt_op_e      op,
  input  logic [K-1:0] label,
  output logic [N-1:0] mask_q
);
  logic [N-1:0] hit;
  logic [N-1:0] mask_d;

  // One-hot decode of the label and per-entry next state
  for (genvar i = 0; i < N; i++) begin : g_entry
    assign hit[i] = upd && (label == K'(i));
    always_comb begin
      mask_d[i] = mask_q[i];
      if (hit[i]) begin
        mask_d[i] = (op == FLT_INJECT);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (upd) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/lutemu_eval.sv
module lutemu_eval
  import lutemu_pkg::*;
#(
  parameter int unsigned K = 6,
  localparam int unsigned N = 1 << K
) (
  input  logic [TAG_W*K-1:0] din,
  input  logic [N-1:0]       table_q,
  input  logic [N-1:0]       mask_q,
  output logic [TAG_W-1:0]   dout,
  output logic               activated
);
  logic [K-1:0] act_idx;
  logic [K-1:0] flt_vec;
  logic [K-1:0] gold_idx;
  logic [N-1:0] upset_table;
  logic         actual_bit;
  logic         golden_bit;
  logic         mismatch;

  for (genvar j = 0; j < K; j++) begin : g_split
    assign act_idx[j] = din[TAG_W*j + VALUE_POS];
    assign flt_vec[j] = din[TAG_W*j + FAULTY_POS];
  end

  assign gold_idx    = act_idx ^ flt_vec;
  assign upset_table = table_q ^ mask_q;
  assign actual_bit  = upset_table[act_idx];
  assign golden_bit  = table_q[gold_idx];
  assign mismatch    = actual_bit ^ golden_bit;

  always_comb begin
    dout             = '0;
    dout[VALUE_POS]  = actual_bit;
    dout[FAULTY_POS] = mismatch;
  end

  assign activated = mask_q[act_idx] & mismatch;
endmodule

// File: rtl/tagged_lut_emu.sv
module tagged_lut_emu
  import lutemu_pkg::*;
#(
  parameter int unsigned K = 6,
  localparam int unsigned N = 1 << K
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [N-1:0]   cfg_table,
  input  logic           flt_valid,
  input  logic           flt_inject,
  input  logic [K-1:0]   flt_label,
  input  logic [2*K-1:0] din,
  output logic [1:0]     dout,
  output logic           activated
);
  logic         rst_n_int;
  logic [N-1:0] table_q;
  logic [N-1:0] mask_q;
  flt_op_e      flt_op;

  assign flt_op = flt_inject ? FLT_INJECT : FLT_CLEAR;

  lutemu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lutemu_table_reg #(.N(N)) u_table (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we      (cfg_we),
    .wdata   (cfg_table),
    .table_q (table_q)
  );

  lutemu_fault_mask #(.K(K)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .upd    (flt_valid),
    .op     (flt_op),
    .label  (flt_label),
    .mask_q (mask_q)
  );

  lutemu_eval #(.K(K)) u_eval (
    .din       (din),
    .table_q   (table_q),
    .mask_q    (mask_q),
    .dout      (dout),
    .activated (activated)
  );
endmodule

// File: rtl/tagged_lut_emu_chk.sv
module tagged_lut_emu_chk #(
  parameter int unsigned K = 6,
  localparam int unsigned N = 1 << K
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [N-1:0]   cfg_table,
  input logic           flt_valid,
  input logic           flt_inject,
  input logic [K-1:0]   flt_label,
  input logic [2*K-1:0] din,
  input logic [1:0]     dout,
  input logic           activated,
  input logic [N-1:0]   table_q,
  input logic [N-1:0]   mask_q
);
  logic [K-1:0] ck_val;
  logic [K-1:0] ck_flt;

  always_comb begin
    for (int j = 0; j < K; j++) begin
      ck_val[j] = din[2*j];
      ck_flt[j] = din[2*j+1];
    end
  end

  AST_TABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> table_q == $past(cfg_table)); // R2

  AST_CLEAN_UNHIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_flt == '0 && !mask_q[ck_val]) |-> (dout[1] == 1'b0)); // R3

  AST_CLEAN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_flt == '0 && mask_q[ck_val]) |-> (dout[1] && activated)); // R3

  AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_inject) |=> mask_q[$past(flt_label)]); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_inject) |=> !mask_q[$past(flt_label)]); // R7

  AST_ACT_FAULTY: assert property (@(posedge clk) disable iff (!rst_n)
    activated |-> dout[1]); // R8

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> $stable(mask_q)); // R9
endmodule

bind tagged_lut_emu tagged_lut_emu_chk #(.K(K)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .cfg_we     (cfg_we),
  .cfg_table  (cfg_table),
  .flt_valid  (flt_valid),
  .flt_inject (flt_inject),
  .flt_label  (flt_label),
  .din        (din),
  .dout       (dout),
  .activated  (activated),
  .table_q    (table_q),
  .mask_q     (mask_q)
);

// File: tb/tagged_lut_emu_test.sv
module tagged_lut_emu_test;
  localparam int K = 3;
  localparam int N = 1 << K;

  logic           clk;
  logic           rst_n;
  logic           cfg_we;
  logic [N-1:0]   cfg_table;
  logic           flt_valid;
  logic           flt_inject;
  logic [K-1:0]   flt_label;
  logic [2*K-1:0] din;
  logic [1:0]     dout;
  logic           activated;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] sh_tbl;
  logic [N-1:0] sh_msk;

  tagged_lut_emu #(.K(K)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_table(cfg_table),
    .flt_valid(flt_valid), .flt_inject(flt_inject), .flt_label(flt_label),
    .din(din), .dout(dout), .activated(activated)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic logic [2*K-1:0] pack(input logic [K-1:0] v, input logic [K-1:0] f);
    logic [2*K-1:0] r;
    for (int j = 0; j < K; j++) r[2*j +: 2] = {f[j], v[j]};
    return r;
  endfunction

  // expected {faulty,value} and activated from the requirements
  task automatic expect_out(input logic [K-1:0] v, input logic [K-1:0] f,
                            output int eo, output int ea);
    logic a, g;
    a = sh_tbl[v] ^ sh_msk[v];
    g = sh_tbl[v ^ f];
    eo = {a != g, a};
    ea = int'(sh_msk[v] && (a != g));
  endtask

  task automatic write_table(input logic [N-1:0] t);
    @(negedge clk); cfg_we = 1; cfg_table = t;
    @(negedge clk); cfg_we = 0; sh_tbl = t;
  endtask

  task automatic fault_cmd(input logic inj, input logic [K-1:0] lbl);
    @(negedge clk); flt_valid = 1; flt_inject = inj; flt_label = lbl;
    @(negedge clk); flt_valid = 0; sh_msk[lbl] = inj;
  endtask

  task automatic sweep_clean(input string req);
    int eo, ea;
    for (int p = 0; p < N; p++) begin
      din = pack(K'(p), '0); #1;
      expect_out(K'(p), '0, eo, ea);
      chk(req, int'(dout), eo);
      chk(req, int'(activated), ea);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int eo, ea;
    rst_n = 0; cfg_we = 0; cfg_table = '0; flt_valid = 0; flt_inject = 0;
    flt_label = '0; din = '0; sh_tbl = '0; sh_msk = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    sweep_clean("R1");

    // R2/R4: majority table, clean sweep
    write_table(8'hE8);
    sweep_clean("R2_R4");

    // R3/R8: single upset at label 3
    fault_cmd(1, 3);
    sweep_clean("R3_R8");
    din = pack(3'd3, '0); #1;
    chk("R3", int'(dout), 2'b10);
    chk("R8", int'(activated), 1);

    // R7: second upset, then clear the first
    fault_cmd(1, 6);
    sweep_clean("R7_two");
    fault_cmd(0, 3);
    sweep_clean("R7_clear");
    din = pack(3'd3, '0); #1;
    chk("R7", int'(dout), 2'b01);

    // R5/R6: all tagged combinations with upset at 6
    for (int v = 0; v < N; v++) begin
      for (int f = 0; f < N; f++) begin
        din = pack(K'(v), K'(f)); #1;
        expect_out(K'(v), K'(f), eo, ea);
        chk("R5_R6", int'(dout), eo);
        chk("R8", int'(activated), ea);
      end
    end

    // R9: reload table, mask at 6 persists
    write_table(8'h0F);
    din = pack(3'd6, '0); #1;
    chk("R9", int'(dout), 2'b11);
    sweep_clean("R9");

    // R6: OR masking of a faulty input
    fault_cmd(0, 6);
    write_table(8'hEE);
    din = pack(3'b011, 3'b010); #1;
    chk("R6", int'(dout), 2'b01);
    din = pack(3'b010, 3'b010); #1;
    chk("R6", int'(dout), 2'b11);

    // R10: write visible at the sampling edge, output combinational
    din = pack(3'd0, '0);
    @(negedge clk); cfg_we = 1; cfg_table = 8'hEF; #1;
    chk("R10", int'(dout), 2'b00);
    @(posedge clk); #1;
    chk("R10", int'(dout), 2'b01);
    cfg_we = 0; sh_tbl = 8'hEF;
    @(negedge clk); flt_valid = 1; flt_inject = 1; flt_label = 3'd0; #1;
    chk("R10", int'(dout), 2'b01);
    @(posedge clk); #1;
    chk("R10", int'(dout), 2'b10);
    flt_valid = 0; sh_msk[0] = 1'b1;
    din = pack(3'd1, '0); #1;
    chk("R10", int'(dout), 2'b01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule